// File: doc/BRIEF.md
# Conditional Render Predicate Evaluator

This block holds the single execute-enable bit that gates the draw commands following a condition-mode write. Each mode write carries a mode code and a condition address. Two modes set the bit directly. Three modes first fetch a four-word compare record from memory and then decide the bit from the sequence and mode fields inside that record. Mode codes that are not recognised leave drawing enabled.

A memory-backed mode reads the record from consecutive addresses, one word per beat: initial sequence, initial mode, current sequence, current mode. While the fetch runs, `busy` is high and `exec_en` keeps its old value. The new value takes effect on the same edge on which `busy` drops. A mode write that arrives while `busy` is high is dropped.

Top module: `cond_pred_eval`

## Requirements
- R1: Mode code 0 (always) sets `exec_en` to 1 on the edge that accepts the write, and `mem_req` stays low.
- R2: Mode code 1 (never) clears `exec_en` on the edge that accepts the write, and `mem_req` stays low.
- R3: Mode code 2 (result nonzero) sets `exec_en` to 1 only when the fetched initial sequence and initial mode words are both nonzero. Otherwise it sets 0.
- R4: Mode code 3 (equal) sets `exec_en` to 1 only when initial sequence equals current sequence and initial mode equals current mode.
- R5: Mode code 4 (not equal) sets `exec_en` to 1 when the two sequences differ or the two modes differ. It sets 0 when both pairs match.
- R6: Mode codes 5, 6 and 7 set `exec_en` to 1 on the accepting edge without any memory request.
- R7: For codes 2 to 4, `busy` rises on the edge that accepts the write and falls on the edge that updates `exec_en`. `exec_en` keeps its prior value in between.
- R8: The record is read as four beats at byte addresses `cond_addr`, +4, +8 and +12, in the word order initial sequence, initial mode, current sequence, current mode. `mem_req` and `mem_addr` hold until `mem_rsp_valid` completes the beat.
- R9: A mode write while `busy` is high is ignored. The fetch in flight, its address and its result are unchanged.
- R10: After reset, `exec_en` is 1, and `busy` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Condition-mode write strobe |
| mode_code | input | 3 | Mode code of the write |
| cond_addr | input | ADDR_W | Byte address of the compare record |
| mem_req | output | 1 | Read request for the current beat |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_rsp_valid | input | 1 | Read data valid; completes the beat |
| mem_rsp_data | input | 32 | Read data word |
| busy | output | 1 | Fetch in progress |
| exec_en | output | 1 | Execute-enable for following draws |

## Verification
On every cycle, the embedded assertions check the following:
- the direct modes and unknown codes set the right value and issue no request;
- `exec_en` holds steady during a fetch;
- beat addresses advance by one word;
- a write made while busy disturbs nothing.

The comparison rules of the three memory-backed modes can only be shown by the bench's scenarios, because they depend on record contents the bench plants. These scenarios include:
- records where only the sequences differ, only the modes differ, or one initial field is zero;
- response latencies from zero to several cycles.

// File: rtl/cond_pred_pkg.sv
// Shared types for the conditional render predicate evaluator.
// Assumes 32-bit record words and a four-word compare record.
package cond_pred_pkg;
    localparam int WORD_W = 32;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        CM_ALWAYS  = 3'd0,
        CM_NEVER   = 3'd1,
        CM_NONZERO = 3'd2,
        CM_EQUAL   = 3'd3,
        CM_DIFFER  = 3'd4
    } cmode_e;

    // Word 0 sits in the least significant slot (the last field).
    typedef struct packed {
        logic [WORD_W-1:0] cur_mode;
        logic [WORD_W-1:0] cur_seq;
        logic [WORD_W-1:0] init_mode;
        logic [WORD_W-1:0] init_seq;
    } cmp_rec_t;

    localparam int REC_BEATS = $bits(cmp_rec_t) / WORD_W;

    // True for the modes whose result depends on the memory record.
    function automatic logic needs_fetch(input logic [MODE_W-1:0] m);
        return (m == CM_NONZERO) || (m == CM_EQUAL) || (m == CM_DIFFER);
    endfunction
endpackage

// File: rtl/cond_rec_fetch.sv
// Fetches the compare record as BEATS consecutive word reads.
// Assumes a request/valid handshake: a beat completes in the cycle where
// the request is high and the response is valid. The last word is passed
// through from the response bus, so the result is ready on the final beat.
module cond_rec_fetch #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       base_i,
    output logic                    req_o,
    output logic [ADDR_W-1:0]       addr_o,
    input  logic                    rsp_valid_i,
    input  logic [WORD_W-1:0]       rsp_data_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [BEATS*WORD_W-1:0] rec_o
);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

    logic              busy_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              last;

    assign accept = busy_q && rsp_valid_i;
    assign last   = (beat_q == LAST);

    // Sequencer: beat counter, address and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            addr_q <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            beat_q <= '0;
            addr_q <= base_i;
        end else if (accept) begin
            if (last) begin
                busy_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
                addr_q <= addr_q + STEP;
            end
        end
    end

    // One holding register per word, except the last.
    for (genvar i = 0; i < BEATS - 1; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        // Capture word i when its beat completes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (accept && beat_q == BEAT_W'(i))
                word_q <= rsp_data_i;
        end
        assign rec_o[i*WORD_W +: WORD_W] = word_q;
    end
    assign rec_o[(BEATS-1)*WORD_W +: WORD_W] = rsp_data_i;

    assign req_o  = busy_q;
    assign addr_o = addr_q;
    assign busy_o = busy_q;
    assign done_o = accept && last;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last) |=> (addr_o == $past(addr_o) + STEP)) // R8
        else $error("beat address did not advance by one word");

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !rsp_valid_i) |=> (req_o && $stable(addr_o))) // R8
        else $error("request dropped or address moved before response");
endmodule

// File: rtl/cond_pred_logic.sv
// Combinational predicate. Turns the mode code and the compare record
// into the execute-enable value. Assumes the record is valid whenever
// it is sampled. Unknown codes yield 1.
module cond_pred_logic
    import cond_pred_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  cmp_rec_t          rec_i,
    output logic              pass_o
);
    logic seq_same;
    logic mode_same;

    assign seq_same  = (rec_i.init_seq  == rec_i.cur_seq);
    assign mode_same = (rec_i.init_mode == rec_i.cur_mode);

    // Mode-specific AND/OR rules over the record fields.
    always_comb begin
        case (mode_i)
            CM_ALWAYS:  pass_o = 1'b1;
            CM_NEVER:   pass_o = 1'b0;
            CM_NONZERO: pass_o = (rec_i.init_seq != '0) && (rec_i.init_mode != '0);
            CM_EQUAL:   pass_o = seq_same && mode_same;
            CM_DIFFER:  pass_o = !seq_same || !mode_same;
            default:    pass_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/cond_pred_eval.sv
// Top of the conditional render predicate evaluator. Accepts mode
// writes when idle and sets execute-enable directly or after a record
// fetch. Assumes a single outstanding fetch; writes while busy are dropped.
module cond_pred_eval
    import cond_pred_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_code,
    input  logic [ADDR_W-1:0] cond_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              busy,
    output logic              exec_en
);
    logic              busy_w;
    logic              done_w;
    logic              accept_wr;
    logic              fetch_mode;
    logic              start_w;
    logic              pass_w;
    logic [MODE_W-1:0] mode_q;
    logic              exec_q;
    logic [$bits(cmp_rec_t)-1:0] rec_flat;
    cmp_rec_t          rec_w;

    assign accept_wr  = mode_wr && !busy_w;
    assign fetch_mode = needs_fetch(mode_code);
    assign start_w    = accept_wr && fetch_mode;
    assign rec_w      = cmp_rec_t'(rec_flat);

    cond_rec_fetch #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .BEATS  (REC_BEATS)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_w),
        .base_i      (cond_addr),
        .req_o       (mem_req),
        .addr_o      (mem_addr),
        .rsp_valid_i (mem_rsp_valid),
        .rsp_data_i  (mem_rsp_data),
        .busy_o      (busy_w),
        .done_o      (done_w),
        .rec_o       (rec_flat)
    );

    cond_pred_logic u_logic (
        .mode_i (mode_q),
        .rec_i  (rec_w),
        .pass_o (pass_w)
    );

    // Latch the mode of each accepted write for the later evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= CM_ALWAYS;
        else if (accept_wr)
            mode_q <= mode_code;
    end

    // Execute-enable: direct modes at once, fetched modes on the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exec_q <= 1'b1;
        else if (accept_wr && !fetch_mode)
            exec_q <= (mode_code != CM_NEVER);
        else if (done_w)
            exec_q <= pass_w;
    end

    assign busy    = busy_w;
    assign exec_en = exec_q;

    AST_ALWAYS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_wr && mode_code == CM_ALWAYS) |=> (exec_en && !mem_req)) // R1
        else $error("always mode did not enable");

    AST_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_wr && mode_code == CM_NEVER) |=> (!exec_en && !mem_req)) // R2
        else $error("never mode did not disable");

    AST_UNKNOWN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_wr && mode_code > 3'd4) |=> (exec_en && !busy)) // R6
        else $error("unknown mode did not enable");

    AST_HOLD_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rsp_valid) |=> $stable(exec_en)) // R7
        else $error("exec_en moved during fetch");

    AST_BUSY_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> busy) // R7
        else $error("busy not raised by fetch mode");

    AST_IGNORE_BUSY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_wr && !mem_rsp_valid) |=> (busy && $stable(mem_addr) && $stable(exec_en))) // R9
        else $error("write while busy disturbed the fetch");
endmodule

// File: tb/cond_pred_eval_tb.sv
// Scoreboard bench: the driver pushes expected exec_en values, the monitor
// pops and compares them when each command completes.
module cond_pred_eval_tb;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_wr = 1'b0;
    logic [2:0]        mode_code = '0;
    logic [ADDR_W-1:0] cond_addr = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              busy;
    logic              exec_en;

    int vectors = 0;
    int fails = 0;
    logic [31:0] mem_words [64];
    logic [ADDR_W-1:0] seen_addr [8];
    int beats = 0;
    int req_cycles = 0;
    int lat_cfg = 0;
    int wait_cnt = 0;
    logic exp_q [$];
    string tag_q [$];
    event result_ev;
    bit done = 0;

    always #4 clk = ~clk;

    cond_pred_eval #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
        .cond_addr(cond_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .exec_en(exec_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Memory responder with configurable latency; records beat addresses.
    always @(negedge clk) begin
        if (mem_req) req_cycles++;
        if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_words[mem_addr[7:2]];
                if (beats < 8) seen_addr[beats] <= mem_addr;
                beats++;
                wait_cnt = lat_cfg;
            end else begin
                mem_rsp_valid <= 1'b0;
                wait_cnt--;
            end
        end else begin
            mem_rsp_valid <= 1'b0;
            wait_cnt = lat_cfg;
        end
    end

    // Monitor: compare each completed command against the scoreboard.
    initial begin
        forever begin
            @(result_ev);
            if (exp_q.size() != 0) begin
                logic e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(exec_en == e, t, exec_en, e);
            end
        end
    end

    task automatic set_rec(input int w, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input logic [31:0] d);
        mem_words[w] = a; mem_words[w+1] = b; mem_words[w+2] = c; mem_words[w+3] = d;
    endtask

    // Driver: issue one mode write, push the expected value, wait for completion.
    task automatic run_cmd(input logic [2:0] m, input int word, input logic exp,
                           input string tag, input bit poke_busy);
        logic prev;
        bit   hold_ok;
        bit   fetch;
        fetch = (m >= 3'd2 && m <= 3'd4);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        beats = 0;
        req_cycles = 0;
        @(negedge clk);
        prev = exec_en;
        mode_wr = 1'b1; mode_code = m; cond_addr = ADDR_W'(word * 4);
        @(negedge clk);
        mode_wr = 1'b0;
        check(busy == fetch, "R7 busy after write", busy, fetch);
        hold_ok = 1;
        if (poke_busy && busy) begin
            mode_wr = 1'b1; mode_code = 3'd1; cond_addr = 16'h0100;
            @(negedge clk);
            mode_wr = 1'b0;
        end
        while (busy) begin
            if (exec_en != prev) hold_ok = 0;
            @(negedge clk);
        end
        -> result_ev;
        #1;
        if (fetch) begin
            check(hold_ok, "R7 exec_en held during fetch", hold_ok, 1);
            check(beats == 4, "R8 beat count", beats, 4);
            for (int i = 0; i < 4; i++)
                check(seen_addr[i] == ADDR_W'((word + i) * 4), "R8 beat address",
                      seen_addr[i], (word + i) * 4);
        end else begin
            check(req_cycles == 0, "R1 R2 R6 no memory request", req_cycles, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem_words[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(exec_en == 1'b1, "R10 exec_en reset", exec_en, 1);
        check(busy == 1'b0, "R10 busy reset", busy, 0);
        check(mem_req == 1'b0, "R10 mem_req reset", mem_req, 0);

        run_cmd(3'd1, 0, 1'b0, "R2 never", 0);
        run_cmd(3'd0, 0, 1'b1, "R1 always", 0);
        run_cmd(3'd1, 0, 1'b0, "R2 never again", 0);

        set_rec(16, 32'd5, 32'd7, 32'd0, 32'd0);
        lat_cfg = 0; run_cmd(3'd2, 16, 1'b1, "R3 both nonzero", 0);
        set_rec(20, 32'd0, 32'd7, 32'd9, 32'd9);
        lat_cfg = 2; run_cmd(3'd2, 20, 1'b0, "R3 seq zero", 0);
        set_rec(24, 32'd5, 32'd0, 32'd9, 32'd9);
        lat_cfg = 1; run_cmd(3'd2, 24, 1'b0, "R3 mode zero", 0);

        set_rec(28, 32'd3, 32'd2, 32'd3, 32'd2);
        lat_cfg = 0; run_cmd(3'd3, 28, 1'b1, "R4 equal match", 0);
        set_rec(32, 32'd3, 32'd2, 32'd4, 32'd2);
        lat_cfg = 3; run_cmd(3'd3, 32, 1'b0, "R4 seq differs", 0);
        set_rec(36, 32'd3, 32'd2, 32'd3, 32'd6);
        lat_cfg = 1; run_cmd(3'd3, 36, 1'b0, "R4 mode differs", 0);

        lat_cfg = 0; run_cmd(3'd4, 28, 1'b0, "R5 all match", 0);
        lat_cfg = 2; run_cmd(3'd4, 32, 1'b1, "R5 seq differs", 0);
        lat_cfg = 0; run_cmd(3'd4, 36, 1'b1, "R5 mode differs", 0);

        for (int m = 5; m < 8; m++) begin
            run_cmd(3'd1, 0, 1'b0, "R6 preset never", 0);
            run_cmd(3'(m), 0, 1'b1, "R6 unknown code", 0);
        end

        run_cmd(3'd1, 0, 1'b0, "R9 preset never", 0);
        lat_cfg = 3; run_cmd(3'd3, 28, 1'b1, "R9 write while busy ignored", 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule